// File: doc/BRIEF.md
# DDR read/write strobe timing generator

This block sits beside the command sequencer of a DDR or DDR2 memory controller. It takes two single-cycle inputs, one for each read command and one for each write command placed on the memory bus. From them it builds three burst-long control windows. `rd_active` opens the data capture stage. `rd_valid` marks the cycles in which returned read data reaches the user side. `wr_active` drives the output enables of the data and data-strobe pins.

Every delay is fixed when the block is built, from its parameters:

- the memory kind;
- the CAS latency;
- the burst length in beats;
- three optional one-cycle pipeline options: a register stage on command outputs, a registered-DIMM stage, and an extra datapath stage;
- the resynchronization cycle count;
- a reclock-to-rising-edge option;
- the number of intermediate resynchronization stages.

Each path is a reset-cleared shift line followed by a burst stretcher. Commands that overlap or follow closely are therefore handled without any counter state.

Top module: `ddr_strobe_timer`

## Requirements
- R1: Every internal stage is cleared by the synchronous active-low reset. One clock after reset is sampled low, `rd_valid` is low. After reset, with both commands held low, all three strobes stay low.
- R2: `rd_active` is high in cycle t exactly when `rd_cmd` was high in at least one of the cycles t-D-BC+1 through t-D. D is the option delay and BC is the burst length in cycles. With no options enabled, the window opens in the same cycle as the read command.
- R3: The option delay D is 1 cycle for each of the options that is set to 1: `CMD_PIPE`, `REG_DIMM` and `DP_PIPE`. The same D applies to both the read and the write windows.
- R4: `rd_valid` equals `rd_active` delayed by 4 + `RESYNC_CYC` + `RECLOCK` + `INTER_STAGES` cycles.
- R5: With `RESYNC_CYC`=2, `RECLOCK`=1 and `INTER_STAGES`=0, `rd_valid` rises exactly 7 cycles after `rd_active` rises.
- R6: With `MEM_KIND`=MEM_DDR (encoding 0), `wr_active` opens D cycles after the write command. With no options, that is the same cycle as the command.
- R7: With `MEM_KIND`=MEM_DDR2 (encoding 1), `wr_active` opens D + `CAS_LAT` - 2 cycles after the write command.
- R8: A lone command gives a window exactly BC = `BURST_BEATS`/2 cycles long on each strobe.
- R9: Commands of one kind spaced BC or fewer cycles apart give one continuous window with no low cycle between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | High for one cycle per read command issued |
| wr_cmd | input | 1 | High for one cycle per write command issued |
| rd_active | output | 1 | Read burst in progress; enables data capture |
| rd_valid | output | 1 | Read data valid at the user interface |
| wr_active | output | 1 | Write burst in progress; enables the data and strobe drivers |

## Verification
The assertions rely on two properties of the inputs:

- `rd_cmd` and `wr_cmd` are sampled only on the rising clock.
- Both commands are low while reset is held. The shift lines then never start with stale history, and the age counters in the checker start saturated.

No limit on command spacing is assumed, so overlapping bursts are legal. The bench holds both commands low through reset. It then applies three kinds of stimulus: isolated pulses, a tight run of reads spaced one burst apart, and a long pseudo-random stream in which overlap and adjacency arise freely.

// File: rtl/ddr_strobe_pkg.sv
package ddr_strobe_pkg;

  typedef enum bit {
    MEM_DDR  = 1'b0,
    MEM_DDR2 = 1'b1
  } mem_kind_e;

  // burst length in clock cycles: two beats per clock
  function automatic int unsigned burst_cycles(input int unsigned beats);
    return (beats < 2) ? 1 : beats / 2;
  endfunction

  // one cycle for every enabled pipeline option
  function automatic int unsigned option_delay(input bit cmd_pipe, input bit reg_dimm,
                                               input bit dp_pipe);
    return 32'(cmd_pipe) + 32'(reg_dimm) + 32'(dp_pipe);
  endfunction

  // distance from capture window to user-side valid window
  function automatic int unsigned valid_lag(input int unsigned resync, input bit reclock,
                                            input int unsigned inter);
    return 4 + resync + 32'(reclock) + inter;
  endfunction

  // extra write offset beyond the option delay
  function automatic int unsigned write_lead(input mem_kind_e kind, input int unsigned cas);
    return (kind == MEM_DDR2 && cas >= 2) ? cas - 2 : 0;
  endfunction

endpackage

// File: rtl/strobe_shift_line.sv
module strobe_shift_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 0) begin : g_through
      assign dout = din;
    end else begin : g_line
      logic [DEPTH-1:0] stg;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg <= '0;
        end else begin
          stg[0] <= din;
          for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/strobe_span_stretch.sv
module strobe_span_stretch #(
  parameter int unsigned SPAN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic active
);
  generate
    if (SPAN <= 1) begin : g_single
      assign active = launch;
    end else begin : g_hist
      localparam int unsigned HW = SPAN - 1;
      logic [HW-1:0] hist;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hist <= '0;
        end else begin
          hist[0] <= launch;
          for (int k = 1; k < int'(HW); k++) hist[k] <= hist[k-1];
        end
      end
      assign active = launch | (|hist);
    end
  endgenerate
endmodule

// File: rtl/ddr_strobe_timer.sv
module ddr_strobe_timer
  import ddr_strobe_pkg::*;
#(
  parameter mem_kind_e   MEM_KIND     = MEM_DDR2,
  parameter int unsigned CAS_LAT      = 4,
  parameter int unsigned BURST_BEATS  = 4,
  parameter bit          CMD_PIPE     = 1'b1,
  parameter bit          REG_DIMM     = 1'b0,
  parameter bit          DP_PIPE      = 1'b0,
  parameter int unsigned RESYNC_CYC   = 2,
  parameter bit          RECLOCK      = 1'b1,
  parameter int unsigned INTER_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cmd,
  input  logic wr_cmd,
  output logic rd_active,
  output logic rd_valid,
  output logic wr_active
);
  localparam int unsigned BURST_CYC = burst_cycles(BURST_BEATS);
  localparam int unsigned OPT_DLY   = option_delay(CMD_PIPE, REG_DIMM, DP_PIPE);
  localparam int unsigned VALID_LAG = valid_lag(RESYNC_CYC, RECLOCK, INTER_STAGES);
  localparam int unsigned WR_DLY    = OPT_DLY + write_lead(MEM_KIND, CAS_LAT);

  // named launch events: first cycle of each delayed burst
  logic rd_launch;
  logic wr_launch;

  // read path: option delay, then burst stretch
  strobe_shift_line #(.DEPTH(OPT_DLY)) u_rd_line (
    .clk(clk), .rst_n(rst_n), .din(rd_cmd), .dout(rd_launch)
  );
  strobe_span_stretch #(.SPAN(BURST_CYC)) u_rd_span (
    .clk(clk), .rst_n(rst_n), .launch(rd_launch), .active(rd_active)
  );

  // valid path: same source as capture window, further delayed
  strobe_shift_line #(.DEPTH(VALID_LAG)) u_valid_line (
    .clk(clk), .rst_n(rst_n), .din(rd_active), .dout(rd_valid)
  );

  // write path: option delay plus memory-kind write latency offset
  strobe_shift_line #(.DEPTH(WR_DLY)) u_wr_line (
    .clk(clk), .rst_n(rst_n), .din(wr_cmd), .dout(wr_launch)
  );
  strobe_span_stretch #(.SPAN(BURST_CYC)) u_wr_span (
    .clk(clk), .rst_n(rst_n), .launch(wr_launch), .active(wr_active)
  );
endmodule

// File: rtl/ddr_strobe_timer_chk.sv
module ddr_strobe_timer_chk
  import ddr_strobe_pkg::*;
#(
  parameter mem_kind_e   MEM_KIND     = MEM_DDR2,
  parameter int unsigned CAS_LAT      = 4,
  parameter int unsigned BURST_BEATS  = 4,
  parameter bit          CMD_PIPE     = 1'b1,
  parameter bit          REG_DIMM     = 1'b0,
  parameter bit          DP_PIPE      = 1'b0,
  parameter int unsigned RESYNC_CYC   = 2,
  parameter bit          RECLOCK      = 1'b1,
  parameter int unsigned INTER_STAGES = 0
) (
  input logic clk,
  input logic rst_n,
  input logic rd_cmd,
  input logic wr_cmd,
  input logic rd_active,
  input logic rd_valid,
  input logic wr_active,
  input logic rd_launch,
  input logic wr_launch
);
  localparam int unsigned BC   = burst_cycles(BURST_BEATS);
  localparam int unsigned OPT  = option_delay(CMD_PIPE, REG_DIMM, DP_PIPE);
  localparam int unsigned VLAG = valid_lag(RESYNC_CYC, RECLOCK, INTER_STAGES);
  localparam int unsigned WTOT = OPT + write_lead(MEM_KIND, CAS_LAT);
  localparam logic [15:0] BC16 = 16'(BC);

  // cycles since the last launch, saturating at BC
  logic [15:0] rd_age, wr_age;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_age <= BC16;
      wr_age <= BC16;
    end else begin
      rd_age <= rd_launch ? 16'd1 : ((rd_age < BC16) ? rd_age + 16'd1 : rd_age);
      wr_age <= wr_launch ? 16'd1 : ((wr_age < BC16) ? wr_age + 16'd1 : wr_age);
    end
  end

  // R1: one clock in reset clears the valid line
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !rd_valid);

  // R2, R8, R9: read window spans BC cycles from each launch
  assert_rd_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active == (rd_launch || (rd_age < BC16)));

  // R8, R9: write window spans BC cycles from each launch
  assert_wr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active == (wr_launch || (wr_age < BC16)));

  // R4: valid window is the capture window VLAG cycles later
  logic [VLAG-1:0] act_hist;
  always_ff @(posedge clk) begin
    if (!rst_n) act_hist <= '0;
    else act_hist <= {act_hist[VLAG-1:0], rd_active} >> 0;
  end
  assert_valid_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == act_hist[VLAG-1]);

  // R3: read launch trails the read command by the option delay
  generate
    if (OPT == 0) begin : g_rd0
      assert_rd_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_launch == rd_cmd);
    end else begin : g_rdn
      logic [OPT-1:0] rc_hist;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rc_hist <= '0;
        end else begin
          rc_hist[0] <= rd_cmd;
          for (int k = 1; k < int'(OPT); k++) rc_hist[k] <= rc_hist[k-1];
        end
      end
      assert_rd_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_launch == rc_hist[OPT-1]);
    end
  endgenerate

  // R6 (DDR) and R7 (DDR2): write launch trails the write command by WTOT
  generate
    if (WTOT == 0) begin : g_wr0
      assert_wr_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_launch == wr_cmd);
    end else begin : g_wrn
      logic [WTOT-1:0] wc_hist;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wc_hist <= '0;
        end else begin
          wc_hist[0] <= wr_cmd;
          for (int k = 1; k < int'(WTOT); k++) wc_hist[k] <= wc_hist[k-1];
        end
      end
      assert_wr_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_launch == wc_hist[WTOT-1]);
    end
  endgenerate
endmodule

bind ddr_strobe_timer ddr_strobe_timer_chk #(
  .MEM_KIND(MEM_KIND), .CAS_LAT(CAS_LAT), .BURST_BEATS(BURST_BEATS),
  .CMD_PIPE(CMD_PIPE), .REG_DIMM(REG_DIMM), .DP_PIPE(DP_PIPE),
  .RESYNC_CYC(RESYNC_CYC), .RECLOCK(RECLOCK), .INTER_STAGES(INTER_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
  .rd_active(rd_active), .rd_valid(rd_valid), .wr_active(wr_active),
  .rd_launch(rd_launch), .wr_launch(wr_launch)
);

// File: tb/test_ddr_strobe_timer.sv
`timescale 1ns/1ps
module test_ddr_strobe_timer;
  localparam int N = 400;

  // config A: DDR2, CL4, 4 beats, command pipe only, R=2, reclock, no inter
  localparam int A_D = 1 + 0 + 0;
  localparam int A_BC = 4 / 2;
  localparam int A_VL = 4 + 2 + 1 + 0;
  localparam int A_WL = 4 - 2;
  // config B: DDR, 8 beats, registered-DIMM + datapath pipe, R=3, no reclock, 2 inter
  localparam int B_D = 0 + 1 + 1;
  localparam int B_BC = 8 / 2;
  localparam int B_VL = 4 + 3 + 0 + 2;
  localparam int B_WL = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_cmd = 1'b0;
  logic wr_cmd = 1'b0;
  logic a_ra, a_rv, a_wa, b_ra, b_rv, b_wa;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  bit rd_h[N];
  bit wr_h[N];
  bit ra_a[N], rv_a[N], wa_a[N], ra_b[N], wa_b[N];

  always #2 clk = ~clk;

  ddr_strobe_timer i_ddr_strobe_timer (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .rd_active(a_ra), .rd_valid(a_rv), .wr_active(a_wa)
  );

  ddr_strobe_timer #(
    .MEM_KIND(ddr_strobe_pkg::MEM_DDR), .CAS_LAT(3), .BURST_BEATS(8),
    .CMD_PIPE(1'b0), .REG_DIMM(1'b1), .DP_PIPE(1'b1),
    .RESYNC_CYC(3), .RECLOCK(1'b0), .INTER_STAGES(2)
  ) i_ddr_strobe_timer_b (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .rd_active(b_ra), .rd_valid(b_rv), .wr_active(b_wa)
  );

  // was a command of the chosen kind seen at a distance lo..lo+len-1 before t
  function automatic bit seen(input bit is_rd, input int t, input int lo, input int len);
    for (int k = lo; k < lo + len; k++) begin
      if (t - k >= 0) begin
        if (is_rd ? rd_h[t-k] : wr_h[t-k]) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // first cycle at or after t0 where the chosen record is high
  function automatic int first_hi(input int sel, input int t0);
    for (int t = t0; t < N; t++) begin
      case (sel)
        0: if (ra_a[t]) return t;
        1: if (rv_a[t]) return t;
        2: if (wa_a[t]) return t;
        3: if (ra_b[t]) return t;
        default: if (wa_b[t]) return t;
      endcase
    end
    return -1;
  endfunction

  function automatic int run_len(input int sel, input int t0);
    int n = 0;
    for (int t = t0; t < N; t++) begin
      bit v;
      case (sel)
        0: v = ra_a[t];
        2: v = wa_a[t];
        3: v = ra_b[t];
        default: v = wa_b[t];
      endcase
      if (!v) return n;
      n++;
    end
    return n;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int t = 0; t < N; t++) begin
      rd_h[t] = 1'b0;
      wr_h[t] = 1'b0;
    end
    rd_h[10] = 1'b1;
    wr_h[40] = 1'b1;
    for (int k = 0; k < 4; k++) rd_h[70 + 2*k] = 1'b1;
    for (int t = 100; t < 350; t++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rd_h[t] = lf[0] & lf[3];
      wr_h[t] = lf[6] & lf[9];
    end

    // reset with commands low
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R1 reset A rd_valid", a_rv, 1'b0);
    chk_bit("R1 reset A rd_active", a_ra, 1'b0);
    chk_bit("R1 reset A wr_active", a_wa, 1'b0);
    chk_bit("R1 reset B rd_valid", b_rv, 1'b0);
    chk_bit("R1 reset B rd_active", b_ra, 1'b0);
    chk_bit("R1 reset B wr_active", b_wa, 1'b0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    for (int t = 0; t < N; t++) begin
      @(posedge clk);
      #1;
      rd_cmd = rd_h[t];
      wr_cmd = wr_h[t];
      @(negedge clk);
      ra_a[t] = a_ra; rv_a[t] = a_rv; wa_a[t] = a_wa;
      ra_b[t] = b_ra; wa_b[t] = b_wa;
      // R2 R3 R4 R6 R7 per cycle against arithmetic windows
      chk_bit($sformatf("R2 A rd_active t=%0d", t), a_ra, seen(1'b1, t, A_D, A_BC));
      chk_bit($sformatf("R4 A rd_valid t=%0d", t), a_rv, seen(1'b1, t, A_D + A_VL, A_BC));
      chk_bit($sformatf("R7 A wr_active t=%0d", t), a_wa, seen(1'b0, t, A_D + A_WL, A_BC));
      chk_bit($sformatf("R3 B rd_active t=%0d", t), b_ra, seen(1'b1, t, B_D, B_BC));
      chk_bit($sformatf("R4 B rd_valid t=%0d", t), b_rv, seen(1'b1, t, B_D + B_VL, B_BC));
      chk_bit($sformatf("R6 B wr_active t=%0d", t), b_wa, seen(1'b0, t, B_D + B_WL, B_BC));
    end
    rd_cmd = 1'b0;
    wr_cmd = 1'b0;

    // R1: quiet after reset until the first command
    chk_int("R1 A quiet before first command", first_hi(0, 0), 11);
    // R3: option delay per config
    chk_int("R3 A read opens after 1 option cycle", first_hi(0, 0), 10 + 1);
    chk_int("R3 B read opens after 2 option cycles", first_hi(3, 0), 10 + 2);
    // R5: valid lags capture by 7
    chk_int("R5 A valid-to-active lag", first_hi(1, 0) - first_hi(0, 0), 7);
    // R6 / R7: write opening
    chk_int("R6 B DDR write opens", first_hi(4, 20), 40 + 2);
    chk_int("R7 A DDR2 write opens", first_hi(2, 20), 40 + 1 + 2);
    // R8: single burst length
    chk_int("R8 A write window length", run_len(2, first_hi(2, 20)), 2);
    chk_int("R8 B write window length", run_len(4, first_hi(4, 20)), 4);
    chk_int("R8 A single read length", run_len(0, 11), 2);
    // R9: back-to-back reads merge
    chk_int("R9 A merged read window", run_len(0, 71), 8);
    chk_int("R9 B merged read window", run_len(3, 72), 10);

    done = 1'b1;
    report();
    $finish;
  end
endmodule